// File: doc/BRIEF.md
# Dual-Start Burst Address Generator

This block produces the internal word address of a synchronous burst SRAM. On any rising clock edge where either of its two start strobes is high, it captures the external address and begins a burst at beat zero. On later edges where the advance strobe is high and no start strobe is high, the two least significant address bits move to the next beat of a four-beat sequence. The upper bits stay as they were loaded.

A strap input picks the beat ordering. When it is low, the order is linear: the start offset plus the beat count, wrapping modulo four. When it is high, the order is interleaved: the start offset XOR the beat count. Because a high level picks interleaved order, a pin that an internal pull-up holds high when left open gives interleaved order. Bursting is optional. A new address can be loaded on every edge, so random access runs at full rate. A flag marks the fourth beat of the current burst.

Top module: `burst_addr_gen`

## Requirements
- R1: A high `start_a` at a rising edge loads `addr_in` into `addr_out` at that edge, at beat 0.
- R2: A high `start_b` at a rising edge loads `addr_in` in the same way as R1.
- R3: When both start strobes are high at the same edge, the address is loaded once and the burst restarts at beat 0. The burst does not step, even if `advance` is also high.
- R4: In interleaved order (`order_lin_n` = 1), the low two bits of `addr_out` equal the loaded low two bits XOR the beat count (0..3).
- R5: In linear order (`order_lin_n` = 0), the low two bits equal the loaded low two bits plus the beat count, modulo 4.
- R6: Bits above bit 1 of `addr_out` keep their loaded value for the whole burst. No carry goes out of the low two bits.
- R7: An advance taken on beat 3 returns the burst to beat 0, which is the loaded address.
- R8: At an edge where `advance` and both start strobes are low, `addr_out` holds its value and `addr_in` is ignored.
- R9: `last_beat` is 1 exactly while the burst is on beat 3 and 0 on every other beat.
- R10: Loads at consecutive edges each take effect at once. No idle cycle is needed, and a load takes priority over a simultaneous advance.
- R11: A low `rst_n` at a rising edge clears `addr_out` to 0 and `last_beat` to 0.
- R12: A high level on `order_lin_n` (the pulled-up, undriven state) selects interleaved order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External address, captured on a start |
| start_a | input | 1 | First burst-start strobe |
| start_b | input | 1 | Second burst-start strobe |
| advance | input | 1 | Step to the next beat |
| order_lin_n | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Current internal address |
| last_beat | output | 1 | High on the fourth beat of a burst |

## Verification
The bench builds the block with ADDR_W = 10. This keeps every address in three hex digits while still leaving eight upper bits. Those upper bits make a false carry out of the low pair visible. For example, a linear burst from offset 3 must wrap to offset 0 with the upper bits unchanged. The chosen start offsets (2, 3 and 1) drive both orderings through all four beats, the wrap back to beat 0, strobe collisions and back-to-back loads.

// File: rtl/burst_pkg.sv
// Package: shared types and constants for the burst address generator.
// Assumes a fixed four-beat burst, so the beat counter is two bits wide.
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_start_ctl.sv
// burst_start_ctl: turns the two start strobes and the advance strobe into
// one load command and one step command. A load always wins over a step.
// Assumes all strobes are synchronous to the consuming register's clock.
module burst_start_ctl (
    input  logic start_a,
    input  logic start_b,
    input  logic advance,
    output logic load,
    output logic step
);

    // Merge the strobes and apply load-over-step priority.
    always_comb begin
        load = start_a | start_b;
        step = advance & ~load;
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// burst_beat_ctr: beat counter for one burst. It clears to 0 on a load,
// increments (wrapping) on a step, and flags the final beat.
// Assumes load and step are never both high (burst_start_ctl ensures this).
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int CNT_W = BEAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] beat,
    output logic             last
);

    localparam logic [CNT_W-1:0] BEAT_MAX = {CNT_W{1'b1}};

    // Beat register: reset, restart on load, advance with wrap on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat <= '0;
        else if (load)
            beat <= '0;
        else if (step)
            beat <= beat + 1'b1;
    end

    // Final-beat flag decoded from the count.
    always_comb last = (beat == BEAT_MAX);

    // R7: a step from the last beat returns to beat 0
    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (last && step) |=> (beat == '0));

    // R3/R1: any load restarts the burst at beat 0
    a_r3_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat == '0 && !last));

endmodule

// File: rtl/burst_seq_map.sv
// burst_seq_map: maps the loaded start offset and the beat count to the
// current low address bits, for either linear or interleaved order.
// Assumes offset and beat have the same width. Purely combinational.
module burst_seq_map
    import burst_pkg::*;
#(
    parameter int OFF_W = BEAT_W
) (
    input  logic [OFF_W-1:0] start_off,
    input  logic [OFF_W-1:0] beat,
    input  burst_order_e     order,
    output logic [OFF_W-1:0] cur_off
);

    logic [OFF_W-1:0] xor_off;
    logic [OFF_W-1:0] sum_off;

    // Interleaved order: bitwise XOR of offset and beat.
    for (genvar i = 0; i < OFF_W; i++) begin : g_ilv_bit
        assign xor_off[i] = start_off[i] ^ beat[i];
    end

    // Linear order: modular sum, carry discarded by the width.
    always_comb sum_off = start_off + beat;

    // Pick the ordering selected by the strap.
    always_comb cur_off = (order == ORD_LINEAR) ? sum_off : xor_off;

endmodule

// File: rtl/burst_addr_gen.sv
// burst_addr_gen: burst address generator for a synchronous burst SRAM.
// It captures the external address on either start strobe, steps the low
// two bits through a four-beat burst on advance, and flags the last beat.
// Assumes the order strap is static during a burst. A high strap selects
// interleaved order, so a pulled-up open pin gives interleaved order.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              start_a,
    input  logic              start_b,
    input  logic              advance,
    input  logic              order_lin_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic              last_beat
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic              step;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cur_off;
    burst_order_e      order;

    // Decode the strap: only a low level selects linear order.
    always_comb order = (order_lin_n == 1'b0) ? ORD_LINEAR : ORD_INTERLEAVE;

    burst_start_ctl u_start (
        .start_a (start_a),
        .start_b (start_b),
        .advance (advance),
        .load    (load),
        .step    (step)
    );

    burst_beat_ctr #(.CNT_W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .beat  (beat),
        .last  (last_beat)
    );

    // Base address register: captures the external address on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (load)
            base_q <= addr_in;
    end

    burst_seq_map #(.OFF_W(BEAT_W)) u_map (
        .start_off (base_q[BEAT_W-1:0]),
        .beat      (beat),
        .order     (order),
        .cur_off   (cur_off)
    );

    // Output address: fixed upper part and sequenced low offset.
    always_comb addr_out = {base_q[ADDR_W-1:BEAT_W], cur_off};

    // R1/R2: a start loads the external address unchanged
    a_r1_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_a || start_b) |=> (addr_out == $past(addr_in)));

    // R6: upper bits do not move while the burst steps
    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !start_a && !start_b) |=>
            (addr_out[ADDR_W-1 -: HI_W] == $past(addr_out[ADDR_W-1 -: HI_W])));

    // R8: with no strobe and a steady strap, the address holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !start_a && !start_b) |=>
            ($stable(order_lin_n) -> $stable(addr_out)));

    // R9: the flag is low straight after any load
    a_r9_flag_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start_a || start_b) |=> !last_beat);

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int AW = 10;

    typedef struct packed {
        logic          sa;
        logic          sb;
        logic          adv;
        logic          lin_n;
        logic [AW-1:0] ain;
        logic [AW-1:0] eaddr;
        logic          elast;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 10'h2A6, 10'h2A6, 1'b0}, // R1 load via start_a
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'h000, 10'h2A7, 1'b0}, // R4 2^1
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'h000, 10'h2A4, 1'b0}, // R4 R6 2^2
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'h000, 10'h2A5, 1'b1}, // R9 2^3 last
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'h000, 10'h2A6, 1'b0}, // R7 wrap
        '{1'b0, 1'b0, 1'b0, 1'b1, 10'h155, 10'h2A6, 1'b0}, // R8 hold
        '{1'b0, 1'b1, 1'b0, 1'b0, 10'h13F, 10'h13F, 1'b0}, // R2 load via start_b
        '{1'b0, 1'b0, 1'b1, 1'b0, 10'h000, 10'h13C, 1'b0}, // R5 R6 3+1 no carry
        '{1'b0, 1'b0, 1'b1, 1'b0, 10'h000, 10'h13D, 1'b0}, // R5 3+2
        '{1'b0, 1'b0, 1'b1, 1'b0, 10'h000, 10'h13E, 1'b1}, // R5 R9 3+3
        '{1'b0, 1'b0, 1'b1, 1'b0, 10'h000, 10'h13F, 1'b0}, // R7 wrap linear
        '{1'b1, 1'b1, 1'b1, 1'b0, 10'h0F1, 10'h0F1, 1'b0}, // R3 both strobes
        '{1'b1, 1'b0, 1'b0, 1'b0, 10'h222, 10'h222, 1'b0}, // R10 back-to-back
        '{1'b0, 1'b1, 1'b1, 1'b0, 10'h3FF, 10'h3FF, 1'b0}, // R10 load beats advance
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'h000, 10'h3FE, 1'b0}, // R12 high strap 3^1
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'h0AA, 10'h3FD, 1'b0}  // R12 3^2, addr_in ignored
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic          start_a;
    logic          start_b;
    logic          advance;
    logic          order_lin_n;
    logic [AW-1:0] addr_out;
    logic          last_beat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_in     (addr_in),
        .start_a     (start_a),
        .start_b     (start_b),
        .advance     (advance),
        .order_lin_n (order_lin_n),
        .addr_out    (addr_out),
        .last_beat   (last_beat)
    );

    task automatic check(input string req, input logic [AW-1:0] ea, input logic el);
        checks++;
        if (addr_out !== ea || last_beat !== el) begin
            errors++;
            $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
                     req, addr_out, last_beat, ea, el);
        end
    endtask

    task automatic drive(input logic sa, input logic sb, input logic adv,
                         input logic ln, input logic [AW-1:0] a);
        @(negedge clk);
        start_a = sa; start_b = sb; advance = adv; order_lin_n = ln; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; start_a = 1'b0; start_b = 1'b0; advance = 1'b0;
        order_lin_n = 1'b1; addr_in = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R11 reset state", 10'h000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].sa, TBL[i].sb, TBL[i].adv, TBL[i].lin_n, TBL[i].ain);
            check($sformatf("vector %0d (R1..R12)", i), TBL[i].eaddr, TBL[i].elast);
        end

        // R8: long hold while addr_in toggles
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1, AW'(k * 10'h111));
            check("R8 hold with toggling addr_in", 10'h3FD, 1'b0);
        end

        // R9: reach beat 3 in interleaved order, then check reset mid-burst
        drive(1'b1, 1'b0, 1'b0, 1'b1, 10'h301);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 10'h000);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 10'h000);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 10'h000);
        check("R9 last beat 1^3", 10'h302, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        advance = 1'b0;
        @(posedge clk);
        #1;
        check("R11 reset mid-burst", 10'h000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: timeout, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule